// File: doc/BRIEF.md
# Multiprocessor Serial Receive Gating Controller

This block is the control and interrupt-gating logic that sits beside an asynchronous serial receiver and transmitter on a multi-drop line. A CPU writes an 8-bit control register over a small register bus. The bit-level deserializer reports each finished frame as a one-cycle strobe. With the strobe come the data byte, the multiprocessor (address) bit, a framing-error indication and an overrun indication. The transmitter reports two events: its data register became empty, and the last frame left the line. The block keeps the status flags and drives four level interrupt requests. It also decodes which role the serial clock pin takes.

On a multi-drop line a slave normally ignores traffic addressed to other stations. Software arms an address-wait mode. While it is armed, every received frame whose multiprocessor bit is 0 is dropped: no flag changes and no interrupt is raised. The first frame carrying multiprocessor bit 1 disarms the mode in hardware. That frame is then handled as an ordinary reception, so software sees the address byte.

Top module: `mp_rx_gate`

## Requirements
- R1: After reset the control register, every status flag, the held receive byte, all four interrupt requests and both clock-pin role outputs are 0.
- R2: A write to address 0 loads the control register, and a read of address 0 returns it. Bit 7 is transmit-irq-enable, bit 6 is receive-irq-enable, bit 5 is transmit-enable, bit 4 is receive-enable, bit 3 is address-wait, bit 2 is transmit-end-irq-enable, and bits 1:0 select the clock role.
- R3: `irq_tx_empty` is high exactly when control bit 7 is 1 and the transmit-empty flag (status bit 3) is set.
- R4: Control bit 6 gates both `irq_rx_full`, which follows receive-full (status bit 0), and `irq_rx_err`, which follows framing-error (bit 1) or overrun (bit 2).
- R5: `irq_tx_end` is high exactly when control bit 2 is 1 and the transmit-end flag (status bit 4) is set.
- R6: While address-wait is 1, a frame with multiprocessor bit 0 sets no status flag, changes no held data and raises no interrupt.
- R7: A frame with multiprocessor bit 1 clears address-wait one cycle after its strobe. The same frame sets receive-full and loads the held byte (address 2).
- R8: When a CPU write of the control register and a hardware clear of address-wait happen in the same cycle, address-wait ends up 0.
- R9: When `sync_mode` is 0, clock-role code 00 drives neither role output, code 01 drives `sck_drive`, and codes 1x drive `sck_sample`.
- R10: When `sync_mode` is 1, codes 00 and 01 drive `sck_drive`, and codes 1x drive `sck_sample`.
- R11: Frame strobes have no effect while receive-enable is 0. Transmit events have no effect while transmit-enable is 0.
- R12: A flag is cleared by writing 0 to its bit at address 1, but only after a read of address 1 (`bus_rd`) has seen that flag as 1. Writing 1, or writing 0 without such a read, leaves the flag set.
- R13: A frame accepted while receive-full is set sets overrun and leaves the held byte unchanged. An accepted frame with `rx_ovr` high also sets overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register select: 0 control, 1 status, 2 received byte |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms flag clearing at address 1) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the selected register |
| sync_mode | input | 1 | 1 selects clocked synchronous mode for the clock-role decode |
| rx_done | input | 1 | Frame-finished strobe from the deserializer |
| rx_data | input | DATA_W | Received byte |
| rx_mpb | input | 1 | Multiprocessor bit of the frame |
| rx_fer | input | 1 | Framing error on the frame |
| rx_ovr | input | 1 | Overrun reported by the deserializer |
| tx_empty | input | 1 | Transmit data register became empty |
| tx_end | input | 1 | Transmission finished |
| irq_tx_empty | output | 1 | Transmit-empty interrupt request |
| irq_rx_full | output | 1 | Receive-full interrupt request |
| irq_rx_err | output | 1 | Receive-error interrupt request |
| irq_tx_end | output | 1 | Transmit-end interrupt request |
| sck_drive | output | 1 | Clock pin driven as output |
| sck_sample | output | 1 | Clock pin used as input |

## Verification
The receive gating is driven with four kinds of frame. An ordinary frame is sent with the receiver idle, and another while receive-full is still set; these separate a first reception from an overrun that must keep the older byte. Under address-wait, a frame with multiprocessor bit 0 and a framing error is sent, then one with bit 1; these separate a dropped frame from the disarming address frame. A frame strobe arriving in the same cycle as a control write shows which side wins the address-wait bit. The flag-clear tests use three sequences: a write of 0 with no prior read, a write of 1 after a read, and a write of 0 after a read. Only the last may clear a flag.

// File: rtl/mp_rx_gate_pkg.sv
package mp_rx_gate_pkg;

    localparam int CTRL_W    = 8;
    localparam int NFLAG     = 5;

    localparam int ADDR_CTRL = 0;
    localparam int ADDR_STAT = 1;
    localparam int ADDR_DATA = 2;

    localparam int FLG_FULL  = 0;
    localparam int FLG_FER   = 1;
    localparam int FLG_OVR   = 2;
    localparam int FLG_TXE   = 3;
    localparam int FLG_TEND  = 4;

    typedef struct packed {
        logic tx_irq_en;
        logic rx_irq_en;
        logic tx_en;
        logic rx_en;
        logic addr_wait;
        logic tend_irq_en;
        logic clk_sel1;
        logic clk_sel0;
    } ctrl_t;

endpackage

// File: rtl/mp_flag_cell.sv
module mp_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr0_i,
    output logic flag_o
);

    typedef struct packed {
        logic flag;
        logic armed;
    } cell_t;

    cell_t cell_d, cell_q;

    always_comb begin
        cell_d = cell_q;
        if (rd_i && cell_q.flag) begin
            cell_d.armed = 1'b1;
        end
        if (wr0_i && cell_q.armed && cell_q.flag) begin
            cell_d.flag  = 1'b0;
            cell_d.armed = 1'b0;
        end
        if (set_i) begin
            cell_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cell_q <= '0;
        end else begin
            cell_q <= cell_d;
        end
    end

    assign flag_o = cell_q.flag;

endmodule

// File: rtl/mp_ctrl_reg.sv
module mp_ctrl_reg
    import mp_rx_gate_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              hw_clr_wait_i,
    output ctrl_t             ctrl_o
);

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_i) begin
            ctrl_d = ctrl_t'(wdata_i[CTRL_W-1:0]);
        end
        if (hw_clr_wait_i) begin
            ctrl_d.addr_wait = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl_o = ctrl_q;

endmodule

// File: rtl/mp_rx_filter.sv
module mp_rx_filter
    import mp_rx_gate_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_t             ctrl_i,
    input  logic              rx_done_i,
    input  logic [DATA_W-1:0] rx_data_i,
    input  logic              rx_mpb_i,
    input  logic              rx_fer_i,
    input  logic              rx_ovr_i,
    input  logic              full_i,
    output logic              set_full_o,
    output logic              set_fer_o,
    output logic              set_ovr_o,
    output logic              hw_clr_wait_o,
    output logic [DATA_W-1:0] hold_o
);

    typedef struct packed {
        logic [DATA_W-1:0] hold;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic   accept;
    logic   drop;
    logic   take;

    always_comb begin
        accept        = rx_done_i && ctrl_i.rx_en;
        drop          = accept && ctrl_i.addr_wait && !rx_mpb_i;
        take          = accept && !drop;
        hw_clr_wait_o = accept && ctrl_i.addr_wait && rx_mpb_i;
        set_full_o    = take && !full_i;
        set_fer_o     = take && !full_i && rx_fer_i;
        set_ovr_o     = take && (full_i || rx_ovr_i);
        st_d          = st_q;
        if (set_full_o) begin
            st_d.hold = rx_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_o = st_q.hold;

endmodule

// File: rtl/mp_irq_clk_map.sv
module mp_irq_clk_map
    import mp_rx_gate_pkg::*;
(
    input  ctrl_t            ctrl_i,
    input  logic [NFLAG-1:0] flags_i,
    input  logic             sync_mode_i,
    output logic             irq_tx_empty_o,
    output logic             irq_rx_full_o,
    output logic             irq_rx_err_o,
    output logic             irq_tx_end_o,
    output logic             sck_drive_o,
    output logic             sck_sample_o
);

    always_comb begin
        irq_tx_empty_o = ctrl_i.tx_irq_en && flags_i[FLG_TXE];
        irq_rx_full_o  = ctrl_i.rx_irq_en && flags_i[FLG_FULL];
        irq_rx_err_o   = ctrl_i.rx_irq_en && (flags_i[FLG_FER] || flags_i[FLG_OVR]);
        irq_tx_end_o   = ctrl_i.tend_irq_en && flags_i[FLG_TEND];
        sck_sample_o   = ctrl_i.clk_sel1;
        if (sync_mode_i) begin
            sck_drive_o = !ctrl_i.clk_sel1;
        end else begin
            sck_drive_o = !ctrl_i.clk_sel1 && ctrl_i.clk_sel0;
        end
    end

endmodule

// File: rtl/mp_rx_gate.sv
module mp_rx_gate
    import mp_rx_gate_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sync_mode,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_mpb,
    input  logic              rx_fer,
    input  logic              rx_ovr,
    input  logic              tx_empty,
    input  logic              tx_end,
    output logic              irq_tx_empty,
    output logic              irq_rx_full,
    output logic              irq_rx_err,
    output logic              irq_tx_end,
    output logic              sck_drive,
    output logic              sck_sample
);

    ctrl_t             ctrl_w;
    logic [NFLAG-1:0]  flags_w;
    logic [NFLAG-1:0]  flag_set;
    logic [DATA_W-1:0] hold_w;
    logic              ctrl_wr;
    logic              stat_wr;
    logic              stat_rd;
    logic              hw_clr_wait;
    logic              set_full;
    logic              set_fer;
    logic              set_ovr;

    assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(ADDR_CTRL));
    assign stat_wr = bus_wr && (bus_addr == ADDR_W'(ADDR_STAT));
    assign stat_rd = bus_rd && (bus_addr == ADDR_W'(ADDR_STAT));

    mp_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_i          (ctrl_wr),
        .wdata_i       (bus_wdata),
        .hw_clr_wait_i (hw_clr_wait),
        .ctrl_o        (ctrl_w)
    );

    mp_rx_filter #(.DATA_W(DATA_W)) u_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctrl_i        (ctrl_w),
        .rx_done_i     (rx_done),
        .rx_data_i     (rx_data),
        .rx_mpb_i      (rx_mpb),
        .rx_fer_i      (rx_fer),
        .rx_ovr_i      (rx_ovr),
        .full_i        (flags_w[FLG_FULL]),
        .set_full_o    (set_full),
        .set_fer_o     (set_fer),
        .set_ovr_o     (set_ovr),
        .hw_clr_wait_o (hw_clr_wait),
        .hold_o        (hold_w)
    );

    always_comb begin
        flag_set           = '0;
        flag_set[FLG_FULL] = set_full;
        flag_set[FLG_FER]  = set_fer;
        flag_set[FLG_OVR]  = set_ovr;
        flag_set[FLG_TXE]  = tx_empty && ctrl_w.tx_en;
        flag_set[FLG_TEND] = tx_end && ctrl_w.tx_en;
    end

    for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
        mp_flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (flag_set[gi]),
            .rd_i   (stat_rd),
            .wr0_i  (stat_wr && !bus_wdata[gi]),
            .flag_o (flags_w[gi])
        );
    end

    mp_irq_clk_map u_map (
        .ctrl_i         (ctrl_w),
        .flags_i        (flags_w),
        .sync_mode_i    (sync_mode),
        .irq_tx_empty_o (irq_tx_empty),
        .irq_rx_full_o  (irq_rx_full),
        .irq_rx_err_o   (irq_rx_err),
        .irq_tx_end_o   (irq_tx_end),
        .sck_drive_o    (sck_drive),
        .sck_sample_o   (sck_sample)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(ADDR_CTRL): bus_rdata[CTRL_W-1:0] = ctrl_w;
            ADDR_W'(ADDR_STAT): bus_rdata[NFLAG-1:0]  = flags_w;
            ADDR_W'(ADDR_DATA): bus_rdata             = hold_w;
            default:            bus_rdata             = '0;
        endcase
    end

endmodule

// File: rtl/mp_rx_gate_chk.sv
module mp_rx_gate_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_done,
    input logic              rx_mpb,
    input logic [7:0]        ctrl,
    input logic [4:0]        flags,
    input logic [DATA_W-1:0] hold,
    input logic              stat_wr,
    input logic              ctrl_wr,
    input logic [DATA_W-1:0] wdata,
    input logic              irq_rx_full,
    input logic              irq_rx_err,
    input logic              sck_drive,
    input logic              sck_sample
);

    AST_WAIT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && ctrl[4] && ctrl[3] && !rx_mpb && !stat_wr)
        |=> ($stable(flags[2:0]) && $stable(hold))); // R6

    AST_WAIT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && ctrl[4] && ctrl[3] && rx_mpb) |=> (!ctrl[3] && flags[0])); // R7

    AST_HW_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && ctrl[4] && ctrl[3] && rx_mpb && ctrl_wr && wdata[3]) |=> !ctrl[3]); // R8

    AST_RX_OFF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !ctrl[4] && !stat_wr) |=> ($stable(flags[2:0]) && $stable(hold))); // R11

    AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && ctrl[4] && flags[0] && !(ctrl[3] && !rx_mpb))
        |=> (flags[2] && $stable(hold))); // R13

    AST_WRITE1_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && wdata[0] && flags[0]) |=> flags[0]); // R12

    AST_RX_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[6] |-> !(irq_rx_full || irq_rx_err)); // R4

    AST_CLK_ROLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(sck_drive && sck_sample)); // R9

endmodule

bind mp_rx_gate mp_rx_gate_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_done     (rx_done),
    .rx_mpb      (rx_mpb),
    .ctrl        (ctrl_w),
    .flags       (flags_w),
    .hold        (hold_w),
    .stat_wr     (stat_wr),
    .ctrl_wr     (ctrl_wr),
    .wdata       (bus_wdata),
    .irq_rx_full (irq_rx_full),
    .irq_rx_err  (irq_rx_err),
    .sck_drive   (sck_drive),
    .sck_sample  (sck_sample)
);

// File: tb/mp_rx_gate_tb.sv
`timescale 1ns/1ps
module mp_rx_gate_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sync_mode = 1'b0;
    logic       rx_done = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_mpb = 1'b0;
    logic       rx_fer = 1'b0;
    logic       rx_ovr = 1'b0;
    logic       tx_empty = 1'b0;
    logic       tx_end = 1'b0;
    logic       irq_tx_empty, irq_rx_full, irq_rx_err, irq_tx_end;
    logic       sck_drive, sck_sample;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int       kind;
        logic [7:0] mask;
        logic [7:0] exp;
        string    req;
    } item_t;

    item_t exp_q[$];
    event  item_ev;

    always #4 clk = ~clk;

    mp_rx_gate u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sync_mode(sync_mode), .rx_done(rx_done), .rx_data(rx_data),
        .rx_mpb(rx_mpb), .rx_fer(rx_fer), .rx_ovr(rx_ovr),
        .tx_empty(tx_empty), .tx_end(tx_end),
        .irq_tx_empty(irq_tx_empty), .irq_rx_full(irq_rx_full),
        .irq_rx_err(irq_rx_err), .irq_tx_end(irq_tx_end),
        .sck_drive(sck_drive), .sck_sample(sck_sample)
    );

    function automatic logic [7:0] observe(int kind);
        case (kind)
            0:       return bus_rdata;
            1:       return {4'b0, irq_tx_end, irq_rx_err, irq_rx_full, irq_tx_empty};
            default: return {6'b0, sck_sample, sck_drive};
        endcase
    endfunction

    // monitor: pops expected items and compares with what the design shows
    initial begin
        forever begin
            @(item_ev);
            #1;
            while (exp_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it  = exp_q.pop_front();
                act = observe(it.kind) & it.mask;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %02h expected %02h", it.req, act, it.exp);
                end
            end
        end
    end

    // kind 0 = register read at addr, 1 = irq vector {tend,err,full,txe}, 2 = {sample,drive}
    task automatic expect_val(int kind, logic [1:0] addr, logic [7:0] mask,
                              logic [7:0] exp, string req);
        item_t it;
        if (kind == 0) bus_addr = addr;
        it.kind = kind; it.mask = mask; it.exp = exp; it.req = req;
        exp_q.push_back(it);
        ->item_ev;
        #2;
    endtask

    task automatic wr_reg(logic [1:0] addr, logic [7:0] data);
        @(negedge clk);
        bus_addr = addr; bus_wdata = data; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic arm_status();
        @(negedge clk);
        bus_addr = 2'd1; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic send_frame(logic [7:0] d, logic mpb, logic fer);
        @(negedge clk);
        rx_data = d; rx_mpb = mpb; rx_fer = fer; rx_done = 1'b1;
        @(negedge clk);
        rx_done = 1'b0; rx_fer = 1'b0;
    endtask

    task automatic tx_event(bit end_evt);
        @(negedge clk);
        if (end_evt) tx_end = 1'b1; else tx_empty = 1'b1;
        @(negedge clk);
        tx_end = 1'b0; tx_empty = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        expect_val(0, 2'd0, 8'hFF, 8'h00, "R1 ctrl");
        expect_val(0, 2'd1, 8'hFF, 8'h00, "R1 status");
        expect_val(0, 2'd2, 8'hFF, 8'h00, "R1 data");
        expect_val(1, 2'd0, 8'hFF, 8'h00, "R1 irq");
        expect_val(2, 2'd0, 8'hFF, 8'h00, "R1 clk");

        // R2 control write/readback
        wr_reg(2'd0, 8'hA5);
        expect_val(0, 2'd0, 8'hFF, 8'hA5, "R2 readback");

        // R9 asynchronous clock roles
        wr_reg(2'd0, 8'h00); expect_val(2, 0, 8'hFF, 8'h00, "R9 code00");
        wr_reg(2'd0, 8'h01); expect_val(2, 0, 8'hFF, 8'h01, "R9 code01");
        wr_reg(2'd0, 8'h02); expect_val(2, 0, 8'hFF, 8'h02, "R9 code10");
        wr_reg(2'd0, 8'h03); expect_val(2, 0, 8'hFF, 8'h02, "R9 code11");
        // R10 synchronous clock roles
        @(negedge clk); sync_mode = 1'b1;
        wr_reg(2'd0, 8'h00); expect_val(2, 0, 8'hFF, 8'h01, "R10 code00");
        wr_reg(2'd0, 8'h01); expect_val(2, 0, 8'hFF, 8'h01, "R10 code01");
        wr_reg(2'd0, 8'h02); expect_val(2, 0, 8'hFF, 8'h02, "R10 code10");
        @(negedge clk); sync_mode = 1'b0;

        // R11 transmit events ignored with transmitter off
        wr_reg(2'd0, 8'h00);
        tx_event(1'b0);
        expect_val(0, 2'd1, 8'h08, 8'h00, "R11 tx off");
        // R3 transmit-empty gating
        wr_reg(2'd0, 8'h20);
        tx_event(1'b0);
        expect_val(0, 2'd1, 8'h08, 8'h08, "R3 flag set");
        expect_val(1, 0, 8'hFF, 8'h00, "R3 irq masked");
        wr_reg(2'd0, 8'hA0);
        expect_val(1, 0, 8'hFF, 8'h01, "R3 irq on");
        // R5 transmit-end gating
        tx_event(1'b1);
        expect_val(0, 2'd1, 8'h10, 8'h10, "R5 flag set");
        expect_val(1, 0, 8'hFF, 8'h01, "R5 irq masked");
        wr_reg(2'd0, 8'hA4);
        expect_val(1, 0, 8'hFF, 8'h09, "R5 irq on");

        // R11 receive ignored with receiver off
        wr_reg(2'd0, 8'h40);
        send_frame(8'hE7, 1'b0, 1'b0);
        expect_val(0, 2'd1, 8'h07, 8'h00, "R11 rx off");
        expect_val(1, 0, 8'h06, 8'h00, "R11 rx off irq");

        // R4 receive-full then R13 overrun
        wr_reg(2'd0, 8'h50);
        send_frame(8'h3C, 1'b0, 1'b0);
        expect_val(0, 2'd1, 8'h07, 8'h01, "R4 full flag");
        expect_val(0, 2'd2, 8'hFF, 8'h3C, "R4 data");
        expect_val(1, 0, 8'hFF, 8'h02, "R4 full irq");
        send_frame(8'h77, 1'b0, 1'b0);
        expect_val(0, 2'd1, 8'h07, 8'h05, "R13 overrun flag");
        expect_val(0, 2'd2, 8'hFF, 8'h3C, "R13 data kept");
        expect_val(1, 0, 8'hFF, 8'h06, "R4 error irq");
        wr_reg(2'd0, 8'h10);
        expect_val(1, 0, 8'hFF, 8'h00, "R4 rie off");

        // R12 flag clearing rules
        wr_reg(2'd1, 8'h00);
        expect_val(0, 2'd1, 8'h07, 8'h05, "R12 no read");
        arm_status();
        wr_reg(2'd1, 8'hFF);
        expect_val(0, 2'd1, 8'h07, 8'h05, "R12 write one");
        wr_reg(2'd1, 8'h00);
        expect_val(0, 2'd1, 8'hFF, 8'h00, "R12 cleared");

        // R6 address-wait drops non-address frames
        wr_reg(2'd0, 8'h58);
        send_frame(8'h11, 1'b0, 1'b1);
        expect_val(0, 2'd1, 8'h07, 8'h00, "R6 no flags");
        expect_val(0, 2'd2, 8'hFF, 8'h3C, "R6 data kept");
        expect_val(1, 0, 8'hFF, 8'h00, "R6 no irq");
        expect_val(0, 2'd0, 8'hFF, 8'h58, "R6 still armed");
        // R7 address frame disarms and is received
        send_frame(8'h42, 1'b1, 1'b0);
        expect_val(0, 2'd0, 8'hFF, 8'h50, "R7 disarmed");
        expect_val(0, 2'd1, 8'h07, 8'h01, "R7 full");
        expect_val(0, 2'd2, 8'hFF, 8'h42, "R7 data");
        expect_val(1, 0, 8'hFF, 8'h02, "R7 irq");

        // R8 hardware clear beats same-cycle write
        arm_status();
        wr_reg(2'd1, 8'h00);
        wr_reg(2'd0, 8'h58);
        @(negedge clk);
        bus_addr = 2'd0; bus_wdata = 8'h58; bus_wr = 1'b1;
        rx_data = 8'h99; rx_mpb = 1'b1; rx_done = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; rx_done = 1'b0;
        expect_val(0, 2'd0, 8'hFF, 8'h50, "R8 hw wins");
        expect_val(0, 2'd2, 8'hFF, 8'h99, "R8 data");

        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule